// File: doc/BRIEF.md
# Serial Flash Fast Read Responder

This block is the device side of a single-bit serial flash read. While chip select is low it takes an 8-bit opcode and then a byte address on the serial input, both sampled on rising edges of the serial clock. It then waits a programmable number of dummy clocks and streams bytes from an on-chip array on the serial output. Output bits change on falling edges, so each one is stable for the host's next rising edge. The byte address rises by one after each byte. At the top of the array it returns to zero, so a single command can read the array again and again.

Two opcodes are recognised. The address length depends on which opcode was sent and on an address-mode bit in the configuration input. The configuration input also carries the latency field that sets the dummy count. Any other opcode puts the block into a silent state until chip select is raised. Raising chip select ends every transfer at once. A write port loads the array contents before a read.

Top module: `sfr_responder`

## Requirements
- R1: While cs_n_i is high, so_oe_o is 0. Raising cs_n_i mid-transfer clears so_oe_o without waiting for a clock edge.
- R2: Opcode 8'h0B with cfg_i[4]=0 is followed by a 3-byte address.
- R3: Opcode 8'h0B with cfg_i[4]=1 is followed by a 4-byte address.
- R4: Opcode 8'h0C is always followed by a 4-byte address, whatever the value of cfg_i[4].
- R5: After the last address bit, the block waits for cfg_i[3:0] rising edges (0 to 15) before data starts. During that wait so_oe_o stays 0.
- R6: Opcode, address and data are sent MSB first. The first data bit appears on the falling edge after the last address or dummy rising edge, with so_oe_o at 1, and each later bit changes on a falling edge.
- R7: After each 8 data bits, the byte address increases by one.
- R8: After byte DEPTH-1 is sent, the next byte comes from address 0, with no gap in the stream.
- R9: Address bits at or above log2(DEPTH) are ignored.
- R10: Any opcode other than 8'h0B and 8'h0C leaves so_oe_o at 0 for the rest of the selection, whatever follows on si_i.
- R11: After an aborted transfer, the next selection starts again in the opcode phase.
- R12: A write through the load port (bd_we_i, sampled on the rising edge of sck_i) replaces the byte that a later read returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sck_i | input | 1 | Serial clock; input sampled on rising edge, output changed on falling edge |
| cs_n_i | input | 1 | Active-low chip select; high is asynchronous abort |
| si_i | input | 1 | Serial data in |
| cfg_i | input | 5 | Bit 4 is the address mode for 8'h0B; bits 3:0 are the dummy clock count |
| bd_we_i | input | 1 | Load-port write enable |
| bd_addr_i | input | log2(DEPTH) | Load-port byte address |
| bd_data_i | input | 8 | Load-port write data |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | High while so_o carries read data |

## Verification
The hardest case to reach is the return from the top byte to byte zero inside one command. To reach it, a read starts two bytes below the top and keeps clocking for four bytes. A second hard case is a 4-byte address whose upper bits are non-zero: a mistake in address length or truncation then appears as a wrong byte. The bench also raises chip select halfway through a byte and then issues a new command, which shows that no phase or counter state survives the abort.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
   typedef enum logic [2:0] {
      PH_OPC    = 3'd0,
      PH_ADDR   = 3'd1,
      PH_DUMMY  = 3'd2,
      PH_DATA   = 3'd3,
      PH_IGNORE = 3'd4
   } phase_t;

   localparam int BYTE_W = 8;
   localparam int CNT_W  = 6;
endpackage

// File: rtl/sfr_mem.sv
module sfr_mem #(
   parameter int DEPTH = 256,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk_i,
   input  logic          we_i,
   input  logic [AW-1:0] wa_i,
   input  logic [7:0]    wd_i,
   input  logic [AW-1:0] ra_i,
   output logic [7:0]    rd_o
);
   logic [7:0] store [DEPTH];

   always_ff @(posedge clk_i) begin
      if (we_i) store[wa_i] <= wd_i;
   end

   assign rd_o = store[ra_i];
endmodule

// File: rtl/sfr_ctrl.sv
module sfr_ctrl
   import sfr_pkg::*;
#(
   parameter int AW     = 8,
   parameter int LAT_W  = 4,
   parameter logic [7:0] OPC_FAST  = 8'h0B,
   parameter logic [7:0] OPC_FAST4 = 8'h0C
) (
   input  logic             sck_i,
   input  logic             cs_n_i,
   input  logic             si_i,
   input  logic             mode_i,
   input  logic [LAT_W-1:0] lat_i,
   output phase_t           phase_o,
   output logic [AW-1:0]    addr_o,
   output logic [2:0]       bit_o
);
   localparam int SW = (AW - 1 > 7) ? AW - 1 : 7;

   phase_t            phase_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [SW-1:0]     sreg_q;
   logic              long_q;
   logic [AW-1:0]     addr_q;
   logic [2:0]        bit_q;

   logic [7:0]        opc_w;
   logic [AW-1:0]     addr_w;
   logic [CNT_W-1:0]  last_addr_w;

   always_comb begin
      opc_w       = {sreg_q[6:0], si_i};
      addr_w      = {sreg_q[AW-2:0], si_i};
      last_addr_w = long_q ? CNT_W'(31) : CNT_W'(23);
   end

   always_ff @(posedge sck_i or posedge cs_n_i) begin
      if (cs_n_i) begin
         phase_q <= PH_OPC;
         cnt_q   <= '0;
         sreg_q  <= '0;
         long_q  <= 1'b0;
         addr_q  <= '0;
         bit_q   <= '0;
      end else begin
         sreg_q <= {sreg_q[SW-2:0], si_i};
         unique case (phase_q)
            PH_OPC: begin
               if (cnt_q == CNT_W'(7)) begin
                  cnt_q <= '0;
                  if (opc_w == OPC_FAST) begin
                     long_q  <= mode_i;
                     phase_q <= PH_ADDR;
                  end else if (opc_w == OPC_FAST4) begin
                     long_q  <= 1'b1;
                     phase_q <= PH_ADDR;
                  end else begin
                     phase_q <= PH_IGNORE;
                  end
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PH_ADDR: begin
               if (cnt_q == last_addr_w) begin
                  cnt_q   <= '0;
                  addr_q  <= addr_w;
                  bit_q   <= '0;
                  phase_q <= (lat_i == '0) ? PH_DATA : PH_DUMMY;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PH_DUMMY: begin
               if (cnt_q == CNT_W'(lat_i) - CNT_W'(1)) begin
                  cnt_q   <= '0;
                  phase_q <= PH_DATA;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PH_DATA: begin
               bit_q <= bit_q + 1'b1;
               if (bit_q == 3'd7) addr_q <= addr_q + 1'b1;
            end
            default: phase_q <= PH_IGNORE;
         endcase
      end
   end

   assign phase_o = phase_q;
   assign addr_o  = addr_q;
   assign bit_o   = bit_q;
endmodule

// File: rtl/sfr_tx.sv
module sfr_tx
   import sfr_pkg::*;
#(
   parameter bit IDLE_HIGH = 1'b0
) (
   input  logic       sck_i,
   input  logic       cs_n_i,
   input  phase_t     phase_i,
   input  logic [2:0] bit_i,
   input  logic [7:0] byte_i,
   output logic       so_o,
   output logic       oe_o
);
   logic       live_w;
   logic       bit_w;

   assign live_w = (phase_i == PH_DATA);
   assign bit_w  = byte_i[3'd7 - bit_i];

   always_ff @(negedge sck_i or posedge cs_n_i) begin
      if (cs_n_i) oe_o <= 1'b0;
      else        oe_o <= live_w;
   end

   generate
      if (IDLE_HIGH) begin : g_idle_hi
         always_ff @(negedge sck_i or posedge cs_n_i) begin
            if (cs_n_i) so_o <= 1'b1;
            else        so_o <= live_w ? bit_w : 1'b1;
         end
      end else begin : g_idle_lo
         always_ff @(negedge sck_i or posedge cs_n_i) begin
            if (cs_n_i) so_o <= 1'b0;
            else        so_o <= live_w & bit_w;
         end
      end
   endgenerate
endmodule

// File: rtl/sfr_responder.sv
module sfr_responder
   import sfr_pkg::*;
#(
   parameter int DEPTH     = 256,
   parameter int LAT_W     = 4,
   parameter bit IDLE_HIGH = 1'b0,
   localparam int AW       = $clog2(DEPTH)
) (
   input  logic             sck_i,
   input  logic             cs_n_i,
   input  logic             si_i,
   input  logic [LAT_W:0]   cfg_i,
   input  logic             bd_we_i,
   input  logic [AW-1:0]    bd_addr_i,
   input  logic [7:0]       bd_data_i,
   output logic             so_o,
   output logic             so_oe_o
);
   initial begin
      if (DEPTH < 4 || (1 << AW) != DEPTH)
         $error("DEPTH must be a power of two, at least 4");
      if (AW > 24)
         $error("DEPTH must fit a 3-byte address");
      if (LAT_W < 1 || LAT_W > 5)
         $error("LAT_W out of range");
   end

   phase_t        phase_w;
   logic [AW-1:0] addr_w;
   logic [2:0]    bit_w;
   logic [7:0]    byte_w;

   sfr_ctrl #(.AW(AW), .LAT_W(LAT_W)) ctrl_i (
      .sck_i   (sck_i),
      .cs_n_i  (cs_n_i),
      .si_i    (si_i),
      .mode_i  (cfg_i[LAT_W]),
      .lat_i   (cfg_i[LAT_W-1:0]),
      .phase_o (phase_w),
      .addr_o  (addr_w),
      .bit_o   (bit_w)
   );

   sfr_mem #(.DEPTH(DEPTH), .AW(AW)) mem_i (
      .clk_i (sck_i),
      .we_i  (bd_we_i),
      .wa_i  (bd_addr_i),
      .wd_i  (bd_data_i),
      .ra_i  (addr_w),
      .rd_o  (byte_w)
   );

   sfr_tx #(.IDLE_HIGH(IDLE_HIGH)) tx_i (
      .sck_i   (sck_i),
      .cs_n_i  (cs_n_i),
      .phase_i (phase_w),
      .bit_i   (bit_w),
      .byte_i  (byte_w),
      .so_o    (so_o),
      .oe_o    (so_oe_o)
   );
endmodule

// File: rtl/sfr_chk.sv
module sfr_chk
   import sfr_pkg::*;
#(
   parameter int AW = 8
) (
   input logic          sck_i,
   input logic          cs_n_i,
   input logic          so_oe_o,
   input phase_t        phase_w,
   input logic [AW-1:0] addr_w,
   input logic [2:0]    bit_w
);
   always @(posedge sck_i) begin
      if (cs_n_i) begin
         p_deselect_quiet_r1: assert (!so_oe_o);
      end
   end

   p_dummy_quiet_r5: assert property (@(posedge sck_i) disable iff (cs_n_i)
      (phase_w == PH_DUMMY) |-> !so_oe_o);

   p_ignore_quiet_r10: assert property (@(posedge sck_i) disable iff (cs_n_i)
      (phase_w == PH_IGNORE) |-> !so_oe_o);

   p_ignore_sticky_r10: assert property (@(posedge sck_i) disable iff (cs_n_i)
      (phase_w == PH_IGNORE) |=> (phase_w == PH_IGNORE));

   p_addr_step_r7: assert property (@(posedge sck_i) disable iff (cs_n_i)
      (phase_w == PH_DATA && bit_w == 3'd7) |=> (addr_w == AW'($past(addr_w) + 1'b1)));

   p_data_live_r6: assert property (@(posedge sck_i) disable iff (cs_n_i)
      so_oe_o |-> (phase_w == PH_DATA));
endmodule

bind sfr_responder sfr_chk #(.AW(AW)) chk_i (
   .sck_i   (sck_i),
   .cs_n_i  (cs_n_i),
   .so_oe_o (so_oe_o),
   .phase_w (phase_w),
   .addr_w  (addr_w),
   .bit_w   (bit_w)
);

// File: tb/sfr_responder_tb_top.sv
`timescale 1ns/1ps
module sfr_responder_tb_top;
   localparam int DEPTH = 256;
   localparam int AW    = $clog2(DEPTH);

   logic          sck = 1'b0;
   logic          cs_n = 1'b1;
   logic          si = 1'b0;
   logic [4:0]    cfg = '0;
   logic          bd_we = 1'b0;
   logic [AW-1:0] bd_addr = '0;
   logic [7:0]    bd_data = '0;
   logic          so, so_oe;

   int n_run = 0;
   int n_fail = 0;
   logic [7:0] model [DEPTH];

   always #2.5 sck = ~sck;

   sfr_responder #(.DEPTH(DEPTH)) dut_i (
      .sck_i(sck), .cs_n_i(cs_n), .si_i(si), .cfg_i(cfg),
      .bd_we_i(bd_we), .bd_addr_i(bd_addr), .bd_data_i(bd_data),
      .so_o(so), .so_oe_o(so_oe)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic load(input int a, input logic [7:0] d);
      @(negedge sck); #1;
      bd_we = 1'b1; bd_addr = AW'(a); bd_data = d;
      @(negedge sck); #1;
      bd_we = 1'b0;
      model[a] = d;
   endtask

   task automatic select();
      @(negedge sck); #1;
      cs_n = 1'b0;
   endtask

   task automatic deselect();
      cs_n = 1'b1; #1;
      @(negedge sck); #1;
   endtask

   task automatic send(input logic [31:0] v, input int nbits);
      for (int i = nbits - 1; i >= 0; i--) begin
         si = v[i];
         @(negedge sck); #1;
      end
   endtask

   task automatic read_byte(input string req, output logic [7:0] v);
      logic all_oe;
      all_oe = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         v[i] = so;
         all_oe &= so_oe;
         @(negedge sck); #1;
      end
      check({req, " oe"}, 32'(all_oe), 32'd1);
   endtask

   task automatic expect_bytes(input string req, input int a, input int n);
      logic [7:0] v;
      for (int k = 0; k < n; k++) begin
         read_byte(req, v);
         check(req, 32'(v), 32'(model[(a + k) % DEPTH]));
      end
   endtask

   task automatic t_reset();
      #1;
      check("R1 idle oe", 32'(so_oe), 32'd0);
   endtask

   task automatic t_fast3();
      cfg = 5'h00;
      select(); send(32'h0B, 8); send(32'h000010, 24);
      expect_bytes("R2 R6 R7 3-byte read", 16, 3);
      deselect();
   endtask

   task automatic t_fast4_mode();
      cfg = 5'h10;
      select(); send(32'h0B, 8); send(32'h00000020, 32);
      expect_bytes("R3 0B 4-byte read", 32, 2);
      deselect();
   endtask

   task automatic t_fast4_op();
      cfg = 5'h00;
      select(); send(32'h0C, 8); send(32'h00000041, 32);
      expect_bytes("R4 0C 4-byte read", 65, 2);
      deselect();
   endtask

   task automatic t_latency(input logic [4:0] c, input int a);
      logic quiet;
      cfg = c;
      quiet = 1'b1;
      select(); send(32'h0B, 8);
      send(32'(a), c[4] ? 32 : 24);
      for (int i = 0; i < int'(c[3:0]); i++) begin
         quiet &= ~so_oe;
         @(negedge sck); #1;
      end
      check("R5 dummy oe low", 32'(quiet), 32'd1);
      expect_bytes("R5 data after dummy", a, 2);
      deselect();
   endtask

   task automatic t_wrap();
      cfg = 5'h00;
      select(); send(32'h0B, 8); send(32'h0000FE, 24);
      expect_bytes("R8 wrap", 254, 4);
      deselect();
   endtask

   task automatic t_high_bits();
      cfg = 5'h03;
      select(); send(32'h0C, 8); send(32'hABCD1277, 32);
      repeat (3) begin @(negedge sck); #1; end
      expect_bytes("R9 upper bits ignored", 8'h77, 1);
      deselect();
   endtask

   task automatic t_ignore();
      logic quiet;
      cfg = 5'h00;
      quiet = 1'b1;
      select(); send(32'h03, 8);
      for (int i = 0; i < 24; i++) begin
         si = i[0];
         quiet &= ~so_oe;
         @(negedge sck); #1;
      end
      send(32'h0B, 8);
      for (int i = 0; i < 40; i++) begin
         si = 1'b0;
         quiet &= ~so_oe;
         @(negedge sck); #1;
      end
      check("R10 unknown opcode silent", 32'(quiet), 32'd1);
      deselect();
   endtask

   task automatic t_abort();
      cfg = 5'h00;
      select(); send(32'h0B, 8); send(32'h000040, 24);
      repeat (4) begin @(negedge sck); #1; end
      check("R1 oe before abort", 32'(so_oe), 32'd1);
      cs_n = 1'b1; #0.5;
      check("R1 abort oe", 32'(so_oe), 32'd0);
      #0.5;
      @(negedge sck); #1;
      select(); send(32'h0B, 8); send(32'h000005, 24);
      expect_bytes("R11 read after abort", 5, 2);
      deselect();
   endtask

   task automatic t_load();
      load(8'h99, 8'h5A);
      cfg = 5'h00;
      select(); send(32'h0B, 8); send(32'h000099, 24);
      expect_bytes("R12 loaded byte", 8'h99, 1);
      deselect();
   endtask

   initial begin
      #1000000;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      for (int a = 0; a < DEPTH; a++) load(a, 8'(a * 37 + 11));
      t_reset();
      t_fast3();
      t_fast4_mode();
      t_fast4_op();
      t_latency(5'h05, 8'h30);
      t_latency(5'h1F, 8'h81);
      t_wrap();
      t_high_bits();
      t_ignore();
      t_abort();
      t_load();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule